// File: doc/BRIEF.md
# Dual-Channel Power-Good Reset Generator

This block watches two supply rails through digital comparator flags and holds an active-low reset for each rail until that rail is judged good. Each channel receives two flags: one set while the rail sits above an upper threshold (94% of nominal), and one set while it sits below a lower threshold (90% of nominal). The gap between the two thresholds gives the decision hysteresis.

A channel becomes good only after its upper flag has stayed set for an entry delay measured in milliseconds. It stops being good only after its lower flag has stayed set for an exit delay measured in microseconds. A flag that drops before its delay runs out clears the timer.

Channel 0 uses fixed delays, about 2 ms for entry and 25 µs for exit. Channel 1 takes one scale input that stands in for a timing capacitor, and both of its delays grow linearly with that value. All delays are converted to clock cycles from a clock-frequency parameter, and every exit delay is held at or above a minimum of 10 µs by default. Each output is a logic level plus a drive-low enable, which together model an open-drain reset pin.

Top module: `pgood_pair`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both channels report not good: `pg_level` = 0 and `pg_pull_low` = 1.
- R2: A not-good channel becomes good exactly after `above_hi` has been sampled high on the number of consecutive rising edges equal to its entry delay. For channel 0 this is `CLK_KHZ*FIX_ENTRY_US/1000` cycles.
- R3: An upper-flag run shorter than the entry delay leaves the channel not good, and the run count starts from zero again after the flag drops.
- R4: A good channel becomes not good exactly after `below_lo` has been sampled high on the number of consecutive edges equal to its exit delay. A shorter run has no lasting effect.
- R5: While good, the channel ignores `above_hi` and also stays good when neither flag is set. While not good, it ignores `below_lo`.
- R6: When `ch_en` is low, the channel is not good from the next edge onward and its timer is cleared. Disable wins over a timer that expires in the same cycle.
- R7: Channel 1 has entry delay `prg_scale*PRG_ENTRY_STEP`, with a floor of 1 cycle. Its exit delay is `prg_scale*PRG_EXIT_STEP`.
- R8: No exit delay is shorter than `CLK_KHZ*EXIT_MIN_US/1000` cycles. A smaller computed value is raised to that minimum.
- R9: `pg_pull_low` is the inverse of `pg_level` on every channel: the reset is driven low exactly when the channel is not good.
- R10: The two channels are independent, so activity on one leaves the other's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | 2 | Per-channel enable (bit 0 = fixed channel, bit 1 = scaled channel) |
| above_hi | input | 2 | Rail above upper (94%) threshold, per channel |
| below_lo | input | 2 | Rail below lower (90%) threshold, per channel |
| prg_scale | input | SCALE_W | Delay multiplier for channel 1 |
| pg_level | output | 2 | Power-good level, 1 = good (reset released) |
| pg_pull_low | output | 2 | Drive-low enable of the reset pin, 1 = reset asserted |

## Verification
A channel can be disabled in the same cycle in which its entry timer would expire. The bench provokes this by holding the upper flag for one cycle less than the entry delay and then dropping the enable on the final qualifying edge. Because disable must take priority, the expected result is a level that stays low. The bench then confirms that the timer was cleared, so a later run shorter than the full delay still does not reach the good state. A second collision comes from changing `prg_scale` between measurements and from sweeping it across values where the computed exit delay lies below, at and above the clamp. Each measured latency is compared with the delay the bench computes from the parameters.

// File: rtl/pgood_pair.sv
module pgood_pair #(
  parameter int CLK_KHZ         = 1000,
  parameter int FIX_ENTRY_US    = 2000,
  parameter int FIX_EXIT_US     = 25,
  parameter int PRG_ENTRY_US    = 20000,
  parameter int PRG_EXIT_NS     = 2500,
  parameter int EXIT_MIN_US     = 10,
  parameter int SCALE_W         = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         ch_en,
  input  logic [1:0]         above_hi,
  input  logic [1:0]         below_lo,
  input  logic [SCALE_W-1:0] prg_scale,
  output logic [1:0]         pg_level,
  output logic [1:0]         pg_pull_low
);

  localparam longint MIN_RAW   = longint'(CLK_KHZ) * EXIT_MIN_US / 1000;
  localparam longint EXIT_MIN  = (MIN_RAW < 1) ? 1 : MIN_RAW;
  localparam longint FE_RAW    = longint'(CLK_KHZ) * FIX_ENTRY_US / 1000;
  localparam longint FIX_ENTRY = (FE_RAW < 1) ? 1 : FE_RAW;
  localparam longint FX_RAW    = longint'(CLK_KHZ) * FIX_EXIT_US / 1000;
  localparam longint FIX_EXIT  = (FX_RAW < EXIT_MIN) ? EXIT_MIN : FX_RAW;
  localparam longint PE_STEP   = longint'(CLK_KHZ) * PRG_ENTRY_US / 1000;
  localparam longint PX_STEP   = longint'(CLK_KHZ) * PRG_EXIT_NS / 1000000;
  localparam longint SCALE_MAX = (longint'(1) << SCALE_W) - 1;
  localparam longint M1        = (FIX_ENTRY > FIX_EXIT) ? FIX_ENTRY : FIX_EXIT;
  localparam longint M2        = (SCALE_MAX * PE_STEP > M1) ? SCALE_MAX * PE_STEP : M1;
  localparam longint M3        = (SCALE_MAX * PX_STEP > M2) ? SCALE_MAX * PX_STEP : M2;
  localparam longint MAX_CYC   = (EXIT_MIN > M3) ? EXIT_MIN : M3;
  localparam int     CNT_W     = $clog2(MAX_CYC + 1);

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic             good;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] entry_lim, exit_lim, lim;
    logic             qual;

    if (g == 0) begin : g_fixed
      assign entry_lim = CNT_W'(FIX_ENTRY);
      assign exit_lim  = CNT_W'(FIX_EXIT);
    end else begin : g_scaled
      logic [CNT_W-1:0] e_raw, x_raw;
      assign e_raw     = CNT_W'(prg_scale) * CNT_W'(PE_STEP);
      assign x_raw     = CNT_W'(prg_scale) * CNT_W'(PX_STEP);
      assign entry_lim = (e_raw == '0) ? CNT_W'(1) : e_raw;
      assign exit_lim  = (x_raw < CNT_W'(EXIT_MIN)) ? CNT_W'(EXIT_MIN) : x_raw;
    end

    assign lim  = good ? exit_lim : entry_lim;
    assign qual = good ? below_lo[g] : above_hi[g];

    always_ff @(posedge clk) begin
      if (!rst_n || !ch_en[g]) begin
        good <= 1'b0;
        cnt  <= '0;
      end else if (!qual) begin
        cnt <= '0;
      end else if (cnt + CNT_W'(1) >= lim) begin
        good <= !good;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end

    assign pg_level[g]    = good;
    assign pg_pull_low[g] = !good;
  end

endmodule

// File: rtl/pgood_pair_chk.sv
module pgood_pair_chk #(
  parameter int MIN_EXIT = 1,
  parameter int CW       = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ch_en,
  input logic [1:0] above_hi,
  input logic [1:0] below_lo,
  input logic [1:0] pg_level
);

  for (genvar i = 0; i < 2; i++) begin : g_chk
    // R6
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |=> !pg_level[i]);
    // R2
    entry_needs_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_level[i]) |-> ($past(above_hi[i]) && $past(ch_en[i])));
    // R4
    exit_needs_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pg_level[i]) && $past(ch_en[i])) |-> $past(below_lo[i]));
    // R5
    good_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[i] && pg_level[i] && !below_lo[i]) |=> pg_level[i]);
    // R5
    bad_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pg_level[i] && !above_hi[i]) |=> !pg_level[i]);
  end

  logic [CW-1:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n || !(pg_level[1] && ch_en[1] && below_lo[1])) run <= '0;
    else if (run != '1) run <= run + CW'(1);
  end

  // R8
  exit_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pg_level[1]) && $past(ch_en[1])) |-> ($past(run) >= CW'(MIN_EXIT - 1)));

endmodule

bind pgood_pair pgood_pair_chk #(.MIN_EXIT(int'(EXIT_MIN)), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .above_hi(above_hi),
  .below_lo(below_lo), .pg_level(pg_level)
);

// File: tb/test_pgood_pair.sv
module test_pgood_pair;
  localparam int PERIOD  = 10;
  localparam int CLK_KHZ = 1000;
  localparam int FE_US   = 12;
  localparam int FX_US   = 4;
  localparam int PE_US   = 5;
  localparam int PX_NS   = 1000;
  localparam int MIN_US  = 3;
  localparam int SW      = 3;
  localparam int FIX_N   = CLK_KHZ * FE_US / 1000;
  localparam int FIX_M   = CLK_KHZ * FX_US / 1000;
  localparam int MIN_C   = CLK_KHZ * MIN_US / 1000;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] ch_en = 0, above_hi = 0, below_lo = 0;
  logic [SW-1:0] prg_scale = 0;
  logic [1:0] pg_level, pg_pull_low;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  pgood_pair #(.CLK_KHZ(CLK_KHZ), .FIX_ENTRY_US(FE_US), .FIX_EXIT_US(FX_US),
    .PRG_ENTRY_US(PE_US), .PRG_EXIT_NS(PX_NS), .EXIT_MIN_US(MIN_US), .SCALE_W(SW))
  i_pgood_pair (.clk(clk), .rst_n(rst_n), .ch_en(ch_en), .above_hi(above_hi),
    .below_lo(below_lo), .prg_scale(prg_scale), .pg_level(pg_level),
    .pg_pull_low(pg_pull_low));

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_lvl(int ch, bit exp, string req);
    chk(pg_level[ch] == exp, req, int'(pg_level[ch]), int'(exp));
    chk(pg_pull_low[ch] == !exp, "R9", int'(pg_pull_low[ch]), int'(!exp));
  endtask

  task automatic latency(int ch, bit want, output int n);
    n = 0;
    do begin tick(); n++; end while (pg_level[ch] != want && n < 500);
  endtask

  task automatic make_good0();
    ch_en[0] = 1; above_hi[0] = 1; tick(FIX_N); above_hi[0] = 0; tick();
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    tick(3);
    chk_lvl(0, 0, "R1"); chk_lvl(1, 0, "R1");
    rst_n = 1; ch_en = 2'b11; tick();
    chk_lvl(0, 0, "R1"); chk_lvl(1, 0, "R1");
    ch_en = 0; tick();

    // R2 / R3: sweep run lengths on the fixed channel
    for (int l = 1; l <= FIX_N + 2; l++) begin
      ch_en[0] = 1; above_hi[0] = 1; tick(l);
      chk_lvl(0, l >= FIX_N, "R2");
      above_hi[0] = 0; tick();
      chk_lvl(0, l >= FIX_N, "R3");
      ch_en[0] = 0; tick();
      chk_lvl(0, 0, "R6");
    end

    // R3: interrupted run restarts
    ch_en[0] = 1; above_hi[0] = 1; tick(FIX_N - 1);
    above_hi[0] = 0; tick();
    above_hi[0] = 1; tick(FIX_N - 1);
    chk_lvl(0, 0, "R3");
    tick();
    chk_lvl(0, 1, "R3");
    above_hi[0] = 0; ch_en[0] = 0; tick();

    // R5: lower flag ignored while not good
    ch_en[0] = 1; below_lo[0] = 1; tick(40);
    chk_lvl(0, 0, "R5");
    below_lo[0] = 0;

    // R4: exit sweep, R5 hold while good
    for (int l = 1; l <= FIX_M + 2; l++) begin
      ch_en[0] = 0; tick(); make_good0();
      above_hi[0] = 1; tick(20); above_hi[0] = 0; tick(20);
      chk_lvl(0, 1, "R5");
      below_lo[0] = 1; tick(l); below_lo[0] = 0; tick();
      chk_lvl(0, l < FIX_M, "R4");
    end

    // R6: disable in the cycle the entry timer expires
    ch_en[0] = 0; tick();
    ch_en[0] = 1; above_hi[0] = 1; tick(FIX_N - 1);
    ch_en[0] = 0; tick();
    chk_lvl(0, 0, "R6");
    ch_en[0] = 1; tick(FIX_N - 1);
    chk_lvl(0, 0, "R6");
    tick();
    chk_lvl(0, 1, "R6");
    above_hi[0] = 0; tick();

    // R7 / R8 / R10: scaled channel sweep while channel 0 stays good
    for (int s = 0; s < (1 << SW); s++) begin
      int ee, xe;
      ee = (PE_US * CLK_KHZ / 1000) * s; if (ee < 1) ee = 1;
      xe = (PX_NS * CLK_KHZ / 1000000) * s; if (xe < MIN_C) xe = MIN_C;
      prg_scale = SW'(s); ch_en[1] = 1; above_hi[1] = 1;
      latency(1, 1, n);
      chk(n == ee, "R7", n, ee);
      above_hi[1] = 0; below_lo[1] = 1;
      latency(1, 0, n);
      chk(n == xe, (s < MIN_C) ? "R8" : "R7", n, xe);
      below_lo[1] = 0; ch_en[1] = 0; tick();
      chk_lvl(0, 1, "R10");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule